// File: doc/BRIEF.md
# Paced Edge Interrupt Combiner

This block merges the level-sensitive interrupt requests of a MAC and its management interface into a single interrupt line for a processor whose interrupt controller reacts only to rising edges. The sources stay high for as long as their condition lasts. If the combined line also stayed high, a second event arriving during service would be lost. A gate input, driven from a software-written enable bit, therefore qualifies the merged line. Software clears the bit when it enters its service routine and sets it again when it leaves. If any source is still high at that point, the line drops and then rises again, so the controller sees a new interrupt.

A pacing timer sets a minimum spacing between successive rising edges of the line. Each time the output rises, the timer loads the programmed count and then counts down once per clock. The output may not rise again until the timer has reached zero. A count of zero turns pacing off. A pacing interval that is running never forces an output that is already high back to low.

A vector output shows the state of every source, registered once. The transmit-pending and receive-pending channels come first, followed by the statistics, host, link-change and command-complete requests. Software reads the vector to find out why the interrupt fired.

Top module: `irq_pace_combiner`

## Requirements
- R1: After reset, `irq_o` is 0 and `vector_o` is 0, and the pacing timer is idle, so the first qualified request raises `irq_o` without waiting.
- R2: `vector_o` shows, one clock after it is sampled, each source at a fixed position. For the default sizes these are: transmit channel i at bit i (0..7), receive channel i at bit 8+i (8..15), statistics at bit 16, host at bit 17, link change at bit 18 and command complete at bit 19.
- R3: When at least one source is high, `gate_en_i` is 1 and the pacing timer is idle, `irq_o` is 1 on the next clock. Every one of the source bits can raise the line on its own.
- R4: When `gate_en_i` is 0, or no source is high, `irq_o` is 0 on the next clock. This holds whatever the state of the pacing timer.
- R5: If `gate_en_i` returns to 1 while a source is still high, `irq_o` rises again. This happens one clock after the gate returns, or as soon as the pacing timer is idle, whichever comes later.
- R6: Let P be the value of `pace_count_i` on the clock at which `irq_o` rose. The next rise of `irq_o` comes no sooner than max(2, P+1) clocks later. When the gate and a source allow it, the rise comes at exactly that bound.
- R7: While `irq_o` is 1, a source stays high and `gate_en_i` stays 1, `irq_o` stays 1, both during the pacing interval and after it has run out.
- R8: A `pace_count_i` of 0 turns pacing off: the line can rise again two clocks after the previous rise, after a single low clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pend_i | input | NUM_TX (8) | Transmit-pending levels, one per channel |
| rx_pend_i | input | NUM_RX (8) | Receive-pending levels, one per channel |
| stat_pend_i | input | 1 | Statistics-pending level |
| host_pend_i | input | 1 | Host-error-pending level |
| link_chg_i | input | 1 | Management link-change level |
| cmd_done_i | input | 1 | Management command-complete level |
| gate_en_i | input | 1 | Software interrupt enable (gate) |
| pace_count_i | input | CNT_W (16) | Pacing interval in clocks; 0 turns pacing off |
| irq_o | output | 1 | Registered combined interrupt line |
| vector_o | output | NUM_TX+NUM_RX+4 (20) | Registered image of all source levels |

## Verification
Two events can fall on the same clock: the gate returning to 1 and the pacing timer reaching zero. The bench holds a source high and records a rise. It then drops the gate for d clocks, with d swept from 1 to 7, against pacing counts P from 0 to 5, so that the re-enable lands before, exactly on, and after the clock at which the timer empties. Each measured distance between rises is compared with max(d+1, P+1). A mismatch shows that one of the two events has been ignored or delayed by one clock.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

   // Number of single-bit sources that follow the channel groups.
   localparam int unsigned MISC_SRCS = 4;

   // Position of each single-bit source inside the vector, relative to its base.
   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_HOST = 1;
   localparam int unsigned OFS_LINK = 2;
   localparam int unsigned OFS_CMD  = 3;

   function automatic int unsigned vec_width(int unsigned n_tx, int unsigned n_rx);
      return n_tx + n_rx + MISC_SRCS;
   endfunction

   function automatic int unsigned rx_base(int unsigned n_tx);
      return n_tx;
   endfunction

   function automatic int unsigned misc_base(int unsigned n_tx, int unsigned n_rx);
      return n_tx + n_rx;
   endfunction

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
   import irq_comb_pkg::*;
#(
   parameter int unsigned NUM_TX = 8,
   parameter int unsigned NUM_RX = 8,
   localparam int unsigned VEC_W = vec_width(NUM_TX, NUM_RX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_TX-1:0] tx_pend_i,
   input  logic [NUM_RX-1:0] rx_pend_i,
   input  logic              stat_pend_i,
   input  logic              host_pend_i,
   input  logic              link_chg_i,
   input  logic              cmd_done_i,
   output logic              any_now_o,
   output logic [VEC_W-1:0]  vec_q_o
);

   localparam int unsigned RXB = rx_base(NUM_TX);
   localparam int unsigned MSB = misc_base(NUM_TX, NUM_RX);

   logic [VEC_W-1:0] vec_d;

   // Place every channel group at its base, one bit per channel.
   for (genvar t = 0; t < NUM_TX; t++) begin : g_tx
      assign vec_d[t] = tx_pend_i[t];
   end
   for (genvar r = 0; r < NUM_RX; r++) begin : g_rx
      assign vec_d[RXB + r] = rx_pend_i[r];
   end
   assign vec_d[MSB + OFS_STAT] = stat_pend_i;
   assign vec_d[MSB + OFS_HOST] = host_pend_i;
   assign vec_d[MSB + OFS_LINK] = link_chg_i;
   assign vec_d[MSB + OFS_CMD]  = cmd_done_i;

   assign any_now_o = |vec_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q_o <= '0;
      else        vec_q_o <= vec_d;
   end

endmodule

// File: rtl/irq_pace_timer.sv
module irq_pace_timer #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          PACE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             idle_o
);

   if (PACE_EN) begin : g_timer
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (load_i)          cnt_q <= load_val_i;
         else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end

      assign idle_o = (cnt_q == '0);
   end else begin : g_no_timer
      logic unused_in;
      assign unused_in = load_i ^ (^load_val_i) ^ clk ^ rst_n;
      assign idle_o    = 1'b1;
   end

endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic any_i,
   input  logic en_i,
   input  logic idle_i,
   output logic rise_o,
   output logic irq_o
);

   logic irq_q;
   logic irq_d;

   // A line already high is held by gate and sources alone; a low line needs the timer idle.
   assign irq_d  = any_i & en_i & (irq_q | idle_i);
   assign rise_o = irq_d & ~irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_d;
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_pace_combiner.sv
module irq_pace_combiner
   import irq_comb_pkg::*;
#(
   parameter int unsigned NUM_TX  = 8,
   parameter int unsigned NUM_RX  = 8,
   parameter int unsigned CNT_W   = 16,
   parameter bit          PACE_EN = 1'b1,
   localparam int unsigned VEC_W  = vec_width(NUM_TX, NUM_RX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_TX-1:0] tx_pend_i,
   input  logic [NUM_RX-1:0] rx_pend_i,
   input  logic              stat_pend_i,
   input  logic              host_pend_i,
   input  logic              link_chg_i,
   input  logic              cmd_done_i,
   input  logic              gate_en_i,
   input  logic [CNT_W-1:0]  pace_count_i,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vector_o
);

   if (NUM_TX < 1 || NUM_TX > 64) begin : g_bad_tx
      $error("irq_pace_combiner: NUM_TX must be 1..64");
   end
   if (NUM_RX < 1 || NUM_RX > 64) begin : g_bad_rx
      $error("irq_pace_combiner: NUM_RX must be 1..64");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("irq_pace_combiner: CNT_W must be 1..32");
   end

   logic any_now;
   logic pace_idle;
   logic out_rise;

   irq_src_capture #(
      .NUM_TX (NUM_TX),
      .NUM_RX (NUM_RX)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_pend_i   (tx_pend_i),
      .rx_pend_i   (rx_pend_i),
      .stat_pend_i (stat_pend_i),
      .host_pend_i (host_pend_i),
      .link_chg_i  (link_chg_i),
      .cmd_done_i  (cmd_done_i),
      .any_now_o   (any_now),
      .vec_q_o     (vector_o)
   );

   irq_pace_timer #(
      .CNT_W   (CNT_W),
      .PACE_EN (PACE_EN)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (out_rise),
      .load_val_i (pace_count_i),
      .idle_o     (pace_idle)
   );

   irq_out_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .any_i  (any_now),
      .en_i   (gate_en_i),
      .idle_i (pace_idle),
      .rise_o (out_rise),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/irq_pace_combiner_chk.sv
module irq_pace_combiner_chk #(
   parameter int unsigned NUM_TX = 8,
   parameter int unsigned NUM_RX = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned VEC_W  = NUM_TX + NUM_RX + 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_TX-1:0] tx_pend_i,
   input logic [NUM_RX-1:0] rx_pend_i,
   input logic              stat_pend_i,
   input logic              host_pend_i,
   input logic              link_chg_i,
   input logic              cmd_done_i,
   input logic              gate_en_i,
   input logic [CNT_W-1:0]  pace_count_i,
   input logic              pace_idle,
   input logic              irq_o,
   input logic [VEC_W-1:0]  vector_o
);

   localparam int unsigned GW = CNT_W + 2;

   logic [VEC_W-1:0] src_cat;
   logic             src_any;
   logic             irq_prev;
   logic             seen_rise;
   logic [GW-1:0]    gap_q;
   logic [CNT_W-1:0] pace_prev;
   logic [CNT_W-1:0] pace_at_rise;
   logic [GW-1:0]    gap_min;

   assign src_cat   = {cmd_done_i, link_chg_i, host_pend_i, stat_pend_i, rx_pend_i, tx_pend_i};
   assign src_any   = |src_cat;
   assign seen_rise = irq_o & ~irq_prev;
   assign gap_min   = (pace_at_rise == '0) ? GW'(2) : (GW'(pace_at_rise) + GW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_prev     <= 1'b0;
         gap_q        <= '1;
         pace_prev    <= '0;
         pace_at_rise <= '0;
      end else begin
         irq_prev  <= irq_o;
         pace_prev <= pace_count_i;
         if (seen_rise) begin
            gap_q        <= GW'(1);
            pace_at_rise <= pace_prev;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> (!irq_o && vector_o == '0));

   assert_vector_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> vector_o == $past(src_cat));

   assert_qualified_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_any && gate_en_i && pace_idle) |=> irq_o);

   assert_gate_or_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en_i || !src_any) |=> !irq_o);

   // R5: a rise needs a source and an open gate one clock earlier
   assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_rise && $past(rst_n)) |-> $past(src_any && gate_en_i));

   assert_pace_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seen_rise |-> gap_q >= gap_min);

   assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && src_any && gate_en_i) |=> irq_o);

endmodule

bind irq_pace_combiner irq_pace_combiner_chk #(
   .NUM_TX (NUM_TX),
   .NUM_RX (NUM_RX),
   .CNT_W  (CNT_W),
   .VEC_W  (VEC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_pend_i    (tx_pend_i),
   .rx_pend_i    (rx_pend_i),
   .stat_pend_i  (stat_pend_i),
   .host_pend_i  (host_pend_i),
   .link_chg_i   (link_chg_i),
   .cmd_done_i   (cmd_done_i),
   .gate_en_i    (gate_en_i),
   .pace_count_i (pace_count_i),
   .pace_idle    (pace_idle),
   .irq_o        (irq_o),
   .vector_o     (vector_o)
);

// File: tb/irq_pace_combiner_tb.sv
module irq_pace_combiner_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NTX = 8;
   localparam int NRX = 8;
   localparam int CW  = 16;
   localparam int VW  = NTX + NRX + 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NTX-1:0] tx_pend = '0;
   logic [NRX-1:0] rx_pend = '0;
   logic           stat_pend = 1'b0;
   logic           host_pend = 1'b0;
   logic           link_chg = 1'b0;
   logic           cmd_done = 1'b0;
   logic           gate_en = 1'b0;
   logic [CW-1:0]  pace = '0;
   logic           irq;
   logic [VW-1:0]  vec;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pace_combiner #(.NUM_TX(NTX), .NUM_RX(NRX), .CNT_W(CW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_pend_i    (tx_pend),
      .rx_pend_i    (rx_pend),
      .stat_pend_i  (stat_pend),
      .host_pend_i  (host_pend),
      .link_chg_i   (link_chg),
      .cmd_done_i   (cmd_done),
      .gate_en_i    (gate_en),
      .pace_count_i (pace),
      .irq_o        (irq),
      .vector_o     (vec)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_src(input logic [VW-1:0] s);
      tx_pend   = s[NTX-1:0];
      rx_pend   = s[NTX+NRX-1:NTX];
      stat_pend = s[16];
      host_pend = s[17];
      link_chg  = s[18];
      cmd_done  = s[19];
   endtask

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      set_src(20'hFFFFF);
      gate_en = 1'b1;
      step();
      step();
      // R1: outputs held at zero through reset despite active inputs
      check("R1 irq in reset", irq, 0);
      check("R1 vector in reset", vec, 0);
      set_src('0);
      gate_en = 1'b0;
      rst_n = 1'b1;
      step();
      check("R1 irq after reset", irq, 0);
      check("R1 vector after reset", vec, 0);
      // R1: timer idle after reset, so first request rises at once even with a large count
      pace = 16'd40;
      set_src(20'h40000);
      gate_en = 1'b1;
      step();
      check("R1 first rise not paced", irq, 1);
      set_src('0);
      step();
      for (int w = 0; w < 45; w++) step();

      // R2/R3: each source bit alone, at its position, gated then released
      pace = '0;
      for (int i = 0; i < VW; i++) begin
         gate_en = 1'b0;
         set_src(VW'(1) << i);
         step();
         check("R2 vector bit position", vec, longint'(1) << i);
         check("R4 gate closed keeps irq low", irq, 0);
         gate_en = 1'b1;
         step();
         check("R3 single source raises irq", irq, 1);
         set_src('0);
         step();
         check("R4 no source drops irq", irq, 0);
         check("R2 vector clears", vec, 0);
      end

      // R2: mixed pattern image
      set_src(20'hA5C3F);
      gate_en = 1'b0;
      step();
      check("R2 vector mixed pattern", vec, 20'hA5C3F);
      set_src('0);
      step();

      // R5/R6/R8: gate dropped for d clocks against pacing count P
      for (int p = 0; p <= 5; p++) begin
         for (int d = 1; d <= 7; d++) begin
            int gap;
            int exp_gap;
            set_src('0);
            gate_en = 1'b1;
            pace = CW'(p);
            for (int w = 0; w < 10; w++) step();
            set_src(20'h80000);
            step();
            check("R3 rise before gap sweep", irq, 1);
            gate_en = 1'b0;
            for (int k = 0; k < d; k++) begin
               step();
               if (k == 0) check("R4 gate drop lowers irq", irq, 0);
            end
            gate_en = 1'b1;
            gap = d;
            while (gap < 30) begin
               step();
               gap++;
               if (irq) break;
            end
            exp_gap = (d + 1 > p + 1) ? d + 1 : p + 1;
            if (p == 0) check("R8 unpaced re-rise", gap, exp_gap);
            else if (d + 1 >= p + 1) check("R5 re-enable edge", gap, exp_gap);
            else check("R6 paced re-rise", gap, exp_gap);
         end
      end

      // R7: line holds through and past a pacing interval
      set_src('0);
      pace = CW'(3);
      for (int w = 0; w < 10; w++) step();
      set_src(20'h00100);
      step();
      check("R7 rise", irq, 1);
      for (int k = 0; k < 8; k++) begin
         step();
         check("R7 stays high", irq, 1);
      end
      // R4: sources drop while timer idle or busy: low next clock
      set_src('0);
      step();
      check("R4 source gone lowers irq", irq, 0);

      // R6: pacing interval bounds a re-rise caused by a new source
      pace = CW'(6);
      for (int w = 0; w < 10; w++) step();
      set_src(20'h00001);
      step();
      check("R6 first rise", irq, 1);
      set_src('0);
      step();
      check("R6 low after source drop", irq, 0);
      set_src(20'h20000);
      begin
         int g;
         g = 1;
         while (g < 30) begin
            step();
            g++;
            if (irq) break;
         end
         check("R6 new source waits for timer", g, 7);
      end
      set_src('0);
      step();

      finish_run();
   end

endmodule